// File: doc/BRIEF.md
# Way-Predicted L1 Data Access Sequencer

This block orders the data-array reads of an 8-way set-associative L1 data cache whose way selection is guessed from the most recently used way of each set. Each set has a small entry that names its last-used way. When a request arrives with prediction allowed, the block reads only that way's data during the tag lookup of all ways. If the tag lookup shows that another way holds the line, the block reads that way's data in a second phase, so the access takes twice as long.

An external confidence unit sends a per-request enable. When the enable is low the block makes no speculative read. It waits for the tag result and then reads only the matching way. This is a serial access that never makes a wasted read. Every response reports the hit, the way, a fast or slow latency class, the number of data-array reads it made, and an outcome code that the confidence unit can train on.

Tag and data storage are modelled as plain register arrays. They are loaded through a write port. One request is handled at a time.

Top module: `wp_l1_seq`

## Requirements
- R1: Reset sets every per-set way entry to way 0, clears all tag valid bits, raises `req_ready` and holds `rsp_valid` low. After reset, a predicted access that hits way 0 of any set reports outcome 0 (correct).
- R2: `req_ready` is high only while no access is open. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low until the edge that raises the `rsp_valid` pulse, and it is high again in that cycle.
- R3: With `req_pred_en` high and the tag match on the predicted way, `rsp_valid` pulses PHASE_CYC edges after acceptance. The response has `rsp_hit`=1, `rsp_slow`=0, `rsp_outcome`=0 (correct), `rsp_probes`=1, and the data of that way.
- R4: With `req_pred_en` high and the tag match on a different way, the response comes 2*PHASE_CYC edges after acceptance. It has `rsp_way` = the matching way, `rsp_slow`=1, `rsp_outcome`=1 (mispredicted), `rsp_probes`=2, and the data of the matching way.
- R5: With `req_pred_en` low and a tag hit, the response comes 2*PHASE_CYC edges after acceptance. It has `rsp_slow`=1, `rsp_outcome`=2 (disabled), `rsp_probes`=1, and the data of the matching way.
- R6: A tag miss gives a response PHASE_CYC edges after acceptance with `rsp_hit`=0, `rsp_slow`=0 and no second read. The outcome is 3 with `rsp_probes`=1 when prediction is on, and 2 with `rsp_probes`=0 when it is off. The set's way entry is left unchanged.
- R7: Every hit, in any mode, writes the matching way into its set's way entry. The next predicted hit to that way in that set is therefore reported as correct.
- R8: A write on the fill port sets the tag valid, the tag and the data of (`fill_set`, `fill_way`). The next access sees the new contents. When tags in a set are unique, each hit reports the way that holds the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_set | input | SET_W (8) | Set index of the access |
| req_tag | input | TAG_W (20) | Tag of the access |
| req_pred_en | input | 1 | Confidence enable: 1 allows the speculative read |
| fill_en | input | 1 | Storage write strobe |
| fill_set | input | SET_W (8) | Set to write |
| fill_way | input | WAY_W (3) | Way to write |
| fill_tag | input | TAG_W (20) | Tag written, marked valid |
| fill_data | input | DATA_W (32) | Data word written |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Tag matched |
| rsp_way | output | WAY_W (3) | Matching way (0 on miss) |
| rsp_slow | output | 1 | 1 = doubled latency class |
| rsp_outcome | output | 2 | 0 correct, 1 mispredicted, 2 disabled, 3 predicted miss |
| rsp_probes | output | 2 | Data-array reads made by this access |
| rsp_data | output | DATA_W (32) | Data read (0 on miss) |

## Verification
A fast result (predicted hit on the guessed way, or any miss) comes PHASE_CYC edges after the accepting edge. A slow result (mispredict, or serial hit) comes 2*PHASE_CYC edges after it. The bench drives each request at a falling edge and counts falling edges from acceptance until `rsp_valid` appears. The count must be exactly the latency plus one. All response fields are then compared at that same falling edge. `req_ready` is sampled at the first falling edge after acceptance and again at the response.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_PROBE2 = 2'd2
    } seq_state_e;

    localparam logic [1:0] OC_CORRECT  = 2'd0;
    localparam logic [1:0] OC_MISPRED  = 2'd1;
    localparam logic [1:0] OC_DISABLED = 2'd2;
    localparam logic [1:0] OC_MISS     = 2'd3;
endpackage

// File: rtl/wp_mru_table.sv
module wp_mru_table #(
    parameter int SETS  = 256,
    parameter int WAY_W = 3,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way
);
    logic [WAY_W-1:0] tbl_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
            tbl_q[wr_set] <= wr_way;
        end
    end

    assign rd_way = tbl_q[rd_set];

    AST_MRU_TAKES_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_set)] == $past(wr_way)); // R7
endmodule

// File: rtl/wp_tag_array.sv
module wp_tag_array #(
    parameter int SETS  = 256,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way
);
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    always_comb begin
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
    end
    assign lk_hit = |match;

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_set)][$past(wr_way)]); // R8
endmodule

// File: rtl/wp_data_array.sv
module wp_data_array #(
    parameter int SETS   = 256,
    parameter int WAYS   = 8,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_set][wr_way] <= wr_data;
    end

    assign rd_data = mem_q[rd_set][rd_way];
endmodule

// File: rtl/wp_l1_seq.sv
module wp_l1_seq
    import wp_pkg::*;
#(
    parameter int SETS      = 256,
    parameter int WAYS      = 8,
    parameter int TAG_W     = 20,
    parameter int DATA_W    = 32,
    parameter int PHASE_CYC = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(PHASE_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_pred_en,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_slow,
    output logic [1:0]        rsp_outcome,
    output logic [1:0]        rsp_probes,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [SET_W-1:0]  set;
        logic [TAG_W-1:0]  tag;
        logic              pen;
        logic [WAY_W-1:0]  pway;
        logic [WAY_W-1:0]  mway;
        logic              rv;
        logic              rhit;
        logic [WAY_W-1:0]  rway;
        logic              rslow;
        logic [1:0]        roc;
        logic [1:0]        rprb;
        logic [DATA_W-1:0] rdat;
    } seq_t;

    seq_t s_d, s_q;

    logic [WAY_W-1:0]  mru_rd_way;
    logic              mru_we;
    logic [WAY_W-1:0]  mru_wway;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [WAY_W-1:0]  rd_way_sel;
    logic [DATA_W-1:0] rd_data;
    logic              phase_end;

    wp_mru_table #(.SETS(SETS), .WAY_W(WAY_W)) u_mru (
        .clk(clk), .rst_n(rst_n),
        .rd_set(req_set), .rd_way(mru_rd_way),
        .wr_en(mru_we), .wr_set(s_q.set), .wr_way(mru_wway)
    );

    wp_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_en), .wr_set(fill_set), .wr_way(fill_way), .wr_tag(fill_tag),
        .lk_set(s_q.set), .lk_tag(s_q.tag), .lk_hit(lk_hit), .lk_way(lk_way)
    );

    assign rd_way_sel = (s_q.st == ST_PROBE2) ? s_q.mway : s_q.pway;

    wp_data_array #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .wr_en(fill_en), .wr_set(fill_set), .wr_way(fill_way), .wr_data(fill_data),
        .rd_set(s_q.set), .rd_way(rd_way_sel), .rd_data(rd_data)
    );

    assign phase_end = (s_q.cnt == CNT_W'(PHASE_CYC - 1));

    always_comb begin
        s_d      = s_q;
        s_d.rv   = 1'b0;
        mru_we   = 1'b0;
        mru_wway = s_q.mway;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_LOOK;
                    s_d.cnt  = '0;
                    s_d.set  = req_set;
                    s_d.tag  = req_tag;
                    s_d.pen  = req_pred_en;
                    s_d.pway = mru_rd_way;
                end
            end
            ST_LOOK: begin
                if (!phase_end) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    s_d.cnt = '0;
                    if (!lk_hit) begin
                        s_d.st    = ST_IDLE;
                        s_d.rv    = 1'b1;
                        s_d.rhit  = 1'b0;
                        s_d.rway  = '0;
                        s_d.rslow = 1'b0;
                        s_d.roc   = s_q.pen ? OC_MISS : OC_DISABLED;
                        s_d.rprb  = s_q.pen ? 2'd1 : 2'd0;
                        s_d.rdat  = '0;
                    end else if (s_q.pen && (lk_way == s_q.pway)) begin
                        s_d.st    = ST_IDLE;
                        s_d.rv    = 1'b1;
                        s_d.rhit  = 1'b1;
                        s_d.rway  = lk_way;
                        s_d.rslow = 1'b0;
                        s_d.roc   = OC_CORRECT;
                        s_d.rprb  = 2'd1;
                        s_d.rdat  = rd_data;
                        mru_we    = 1'b1;
                        mru_wway  = lk_way;
                    end else begin
                        s_d.st   = ST_PROBE2;
                        s_d.mway = lk_way;
                    end
                end
            end
            ST_PROBE2: begin
                if (!phase_end) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end else begin
                    s_d.cnt   = '0;
                    s_d.st    = ST_IDLE;
                    s_d.rv    = 1'b1;
                    s_d.rhit  = 1'b1;
                    s_d.rway  = s_q.mway;
                    s_d.rslow = 1'b1;
                    s_d.roc   = s_q.pen ? OC_MISPRED : OC_DISABLED;
                    s_d.rprb  = s_q.pen ? 2'd2 : 2'd1;
                    s_d.rdat  = rd_data;
                    mru_we    = 1'b1;
                    mru_wway  = s_q.mway;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign rsp_valid   = s_q.rv;
    assign rsp_hit     = s_q.rhit;
    assign rsp_way     = s_q.rway;
    assign rsp_slow    = s_q.rslow;
    assign rsp_outcome = s_q.roc;
    assign rsp_probes  = s_q.rprb;
    assign rsp_data    = s_q.rdat;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_CORRECT_IS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OC_CORRECT) |-> (rsp_hit && !rsp_slow && rsp_probes == 2'd1)); // R3
    AST_MISPRED_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OC_MISPRED) |-> (rsp_hit && rsp_slow && rsp_probes == 2'd2)); // R4
    AST_DISABLED_NO_WASTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OC_DISABLED) |-> (rsp_probes == {1'b0, rsp_hit})); // R5
    AST_MISS_NO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_slow && rsp_probes <= 2'd1)); // R6
endmodule

// File: tb/wp_l1_seq_tb.sv
`timescale 1ns/1ps
module wp_l1_seq_tb;
    localparam int PH = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_pred_en;
    logic [7:0]  req_set;
    logic [19:0] req_tag;
    logic        fill_en;
    logic [7:0]  fill_set;
    logic [2:0]  fill_way;
    logic [19:0] fill_tag;
    logic [31:0] fill_data;
    logic        rsp_valid, rsp_hit, rsp_slow;
    logic [2:0]  rsp_way;
    logic [1:0]  rsp_outcome, rsp_probes;
    logic [31:0] rsp_data;

    wp_l1_seq #(.PHASE_CYC(PH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_set(req_set),
        .req_tag(req_tag), .req_pred_en(req_pred_en),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_slow(rsp_slow), .rsp_outcome(rsp_outcome), .rsp_probes(rsp_probes),
        .rsp_data(rsp_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_oc;

    logic [19:0] m_tag [256][8];
    bit          m_vld [256][8];
    logic [31:0] m_dat [256][8];
    int          m_mru [256];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int find_way(input int s, input logic [19:0] t);
        for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic logic [19:0] hit_tag(input int w);
        return {1'b0, 3'(w), 16'($urandom)};
    endfunction

    function automatic logic [19:0] miss_tag();
        return {1'b1, 19'($urandom)};
    endfunction

    task automatic fill(input int s, input int w, input logic [19:0] t, input logic [31:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_set = 8'(s); fill_way = 3'(w); fill_tag = t; fill_data = d;
        @(negedge clk);
        fill_en = 1'b0;
        m_tag[s][w] = t; m_vld[s][w] = 1'b1; m_dat[s][w] = d;
    endtask

    task automatic do_access(input int s, input logic [19:0] t, input bit pen);
        int w, lat, exp_lat, exp_oc, exp_prb;
        bit exp_slow;
        string rq;
        w = find_way(s, t);
        if (w < 0) begin
            exp_lat = PH; exp_oc = pen ? 3 : 2; exp_prb = pen ? 1 : 0; exp_slow = 0; rq = "R6";
        end else if (pen && w == m_mru[s]) begin
            exp_lat = PH; exp_oc = 0; exp_prb = 1; exp_slow = 0; rq = "R3";
        end else begin
            exp_lat = 2 * PH; exp_oc = pen ? 1 : 2; exp_prb = pen ? 2 : 1; exp_slow = 1;
            rq = pen ? "R4" : "R5";
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_set = 8'(s); req_tag = t; req_pred_en = pen;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
        while (!rsp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat + 1, rq, "latency", lat - 1, exp_lat);
        chk(rsp_hit == (w >= 0), rq, "hit", rsp_hit, (w >= 0));
        chk(rsp_slow == exp_slow, rq, "slow", rsp_slow, exp_slow);
        chk(rsp_outcome == 2'(exp_oc), rq, "outcome", rsp_outcome, exp_oc);
        chk(rsp_probes == 2'(exp_prb), rq, "probes", rsp_probes, exp_prb);
        chk(req_ready == 1'b1, "R2", "ready at response", req_ready, 1);
        if (w >= 0) begin
            chk(rsp_way == 3'(w), "R8", "way", rsp_way, w);
            chk(rsp_data == m_dat[s][w], rq, "data", rsp_data, m_dat[s][w]);
            m_mru[s] = w;
        end
        last_oc = int'(rsp_outcome);
    endtask

    initial begin
        logic [19:0] old_tag;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 256; s++) begin
            m_mru[s] = 0;
            for (int w = 0; w < 8; w++) m_vld[s][w] = 1'b0;
        end
        rst_n = 1'b0; req_valid = 1'b0; req_pred_en = 1'b0; req_set = '0; req_tag = '0;
        fill_en = 1'b0; fill_set = '0; fill_way = '0; fill_tag = '0; fill_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        for (int w = 0; w < 8; w++) fill(5, w, {1'b0, 3'(w), 16'h1000 + 16'(w)}, 32'hA500_0000 + 32'(w));

        // R1: reset way entry is 0, so way 0 is predicted correctly
        do_access(5, m_tag[5][0], 1'b1);
        chk(last_oc == 0, "R1", "reset prediction way 0", last_oc, 0);
        // R4 then R7: mispredict trains the entry
        do_access(5, m_tag[5][3], 1'b1);
        do_access(5, m_tag[5][3], 1'b1);
        chk(last_oc == 0, "R7", "after mispredict", last_oc, 0);
        // R5 then R7: serial hit also trains the entry
        do_access(5, m_tag[5][6], 1'b0);
        do_access(5, m_tag[5][6], 1'b1);
        chk(last_oc == 0, "R7", "after serial hit", last_oc, 0);
        // R6: misses leave the entry untouched
        do_access(5, miss_tag(), 1'b1);
        do_access(5, miss_tag(), 1'b0);
        do_access(5, m_tag[5][6], 1'b1);
        chk(last_oc == 0, "R6", "entry kept after miss", last_oc, 0);
        // R8: overwrite way 2, old tag misses, new tag hits
        old_tag = m_tag[5][2];
        fill(5, 2, {1'b0, 3'd2, 16'hBEEF}, 32'h1234_5678);
        do_access(5, old_tag, 1'b1);
        chk(last_oc == 3, "R8", "old tag gone", last_oc, 3);
        do_access(5, {1'b0, 3'd2, 16'hBEEF}, 1'b1);
        chk(last_oc == 1, "R8", "new tag found", last_oc, 1);

        for (int s = 0; s < 32; s++)
            for (int w = 0; w < 8; w++)
                if ($urandom_range(0, 3) != 0) fill(s, w, hit_tag(w), $urandom);

        for (int n = 0; n < 400; n++) begin
            int s, w;
            logic [19:0] t;
            s = $urandom_range(0, 31);
            w = $urandom_range(0, 7);
            if ($urandom_range(0, 4) != 0 && m_vld[s][w]) begin
                if ($urandom_range(0, 1) == 1) w = m_mru[s];
                t = m_vld[s][w] ? m_tag[s][w] : miss_tag();
            end else begin
                t = miss_tag();
            end
            do_access(s, t, $urandom_range(0, 3) != 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule